// File: doc/BRIEF.md
# Command/Response Buffer Controller

This block is the per-locality command/response engine behind a byte-wide register port on a trusted-module interface. The port has two windows, a status register and a data FIFO. The host puts the machine into its ready state with a status write. It then streams a command into a shared byte buffer, one byte per data write. The command carries its own total length in a header. The controller tracks how many bytes are still missing through an "expecting more" flag. Once the command is complete, a go write hands the byte count to an execution engine through a request pulse.

The engine writes its response into the same buffer and signals completion. The host then reads the response back through the data window. The status word reports flags and a burst count. While a response is pending, the burst count is the number of bytes left to read. Otherwise it is the free space in the buffer.

Five states (idle, ready, reception, execution, completion) decide whether each status write and data byte is acted on, dropped or turned into an abort. An abort during execution is forwarded to the engine as a cancel pulse. It finishes when the engine completes. Locality arbitration and interrupt masking sit outside this block. The three event outputs are unmasked one-cycle pulses.

Top module: `crb_ctrl`

## Requirements
- R1: After reset the state is idle, all status flags read 0, the burst count equals BUF_BYTES, and bits 29:28 of the status word carry the FAMILY parameter in every cycle.
- R2: A status write is acted on only when exactly one of its bits 6 (command-ready), 5 (go) and 1 (response-retry) is set. Any write with two or three of them set changes no flag, no count and no state.
- R3: Command-ready in idle enters ready, sets flag bit 6 and pulses ev_cmd_ready. Command-ready in ready only rewinds the buffer offset to 0.
- R4: A data write in ready stores the byte, enters reception, clears bit 6, and sets valid (bit 7) and expect (bit 3). Data writes in idle, execution or completion are dropped, leaving the flags and the burst count unchanged.
- R5: The command length is the big-endian 32-bit value in buffer bytes 2..5. Once more than 5 bytes are held, expect stays set while this length exceeds the byte count and clears as soon as it does not.
- R6: Go is taken only in reception with expect clear. It pulses eng_req one cycle later with eng_len equal to the bytes received and enters execution. Go at any other time changes nothing.
- R7: On eng_ack in execution the offset returns to 0 and the state becomes completion. Valid and data-available (bit 4) are set, expect and command-ready are cleared, and ev_valid and ev_data_avail pulse.
- R8: In completion with data-available set, a data read returns the buffer byte at the offset and advances it. The read that reaches the response length (header bytes 2..5, capped at BUF_BYTES) clears data-available, keeps valid set and pulses ev_valid. Every other data read returns 0xFF.
- R9: Response-retry in completion rewinds the offset to 0 and sets valid and data-available again, so the response can be read from its first byte.
- R10: The burst count (status bits 23:8) is the response length minus the offset while data-available is set, and BUF_BYTES minus the offset otherwise. It is capped at 255 while bus_narrow is high.
- R11: Command-ready in reception aborts at once: offset 0, ready state, only bit 6 set, ev_cmd_ready pulse. In execution it pulses eng_cancel. The next eng_ack then leaves the block in ready with only bit 6 set, not in completion.
- R12: Command-ready in completion rewinds the offset, enters ready, sets bit 6 with an ev_cmd_ready pulse (only if bit 6 was clear) and clears data-available and valid.
- R13: Status bit 2 (self-test done) is set by eng_ack together with eng_selftest. Only reset clears it, and no flag update disturbs it or the family bits.
- R14: The offset never exceeds BUF_BYTES. A data byte arriving while expect is set and the buffer is full is dropped and clears expect, leaving valid set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only on the data window) |
| bus_fifo | input | 1 | 1 selects the data window, 0 the status register |
| bus_narrow | input | 1 | Current access is a single byte; caps the burst count at 255 |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Data window read byte (0xFF filler when nothing is available) |
| sts_rdata | output | 32 | Status word: bits 7,6,4,3,2 flags, 23:8 burst count, 29:28 family |
| eng_req | output | 1 | One-cycle request to the execution engine |
| eng_len | output | clog2(BUF_BYTES+1) | Command byte count, valid with eng_req |
| eng_cancel | output | 1 | One-cycle cancel request for an executing command |
| eng_wr | input | 1 | Engine write of a response byte |
| eng_waddr | input | clog2(BUF_BYTES) | Engine write address |
| eng_wdata | input | 8 | Engine write byte |
| eng_ack | input | 1 | Engine completion pulse |
| eng_selftest | input | 1 | With eng_ack: self-test has completed |
| ev_cmd_ready | output | 1 | Command-ready event pulse |
| ev_valid | output | 1 | Status-valid event pulse |
| ev_data_avail | output | 1 | Data-available event pulse |

## Verification
The assertions assume that eng_ack and bus operations never fall in the same cycle, and that bus_wr and bus_rd are never high together. They also assume the engine writes the buffer only between eng_req and eng_ack. The bench enforces this by running every bus access, engine write and acknowledge as a separate sequential task, one operation per clock. Command lengths are swept across the header boundary, response lengths are tied to each command, and the boundary cases are driven on purpose: a full buffer, an abort in each busy state, and a burst count above 255.

// File: rtl/crb_pkg.sv
package crb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READY = 3'd1,
        ST_RECV  = 3'd2,
        ST_EXEC  = 3'd3,
        ST_DONE  = 3'd4
    } crb_state_e;

    // Status byte bit positions (host visible)
    localparam int BIT_VALID  = 7;
    localparam int BIT_CMDRDY = 6;
    localparam int BIT_GO     = 5;
    localparam int BIT_DAV    = 4;
    localparam int BIT_MORE   = 3;
    localparam int BIT_STEST  = 2;
    localparam int BIT_RETRY  = 1;

    localparam logic [7:0] FILL_BYTE = 8'hFF;
    localparam int HDR_FIRST = 2;
    localparam int HDR_BYTES = 4;
    localparam int HDR_END   = HDR_FIRST + HDR_BYTES; // byte count that completes the header

    typedef struct packed {
        logic valid;
        logic cmd_rdy;
        logic dav;
        logic more;
    } crb_flags_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READY,
        OP_GO,
        OP_RETRY
    } crb_op_e;

    // A status write counts only when exactly one action bit is set
    function automatic crb_op_e decode_op(input logic [7:0] b);
        crb_op_e op;
        case ({b[BIT_CMDRDY], b[BIT_GO], b[BIT_RETRY]})
            3'b100:  op = OP_READY;
            3'b010:  op = OP_GO;
            3'b001:  op = OP_RETRY;
            default: op = OP_NONE;
        endcase
        return op;
    endfunction

    function automatic crb_flags_t flags_of(input logic valid, input logic cmd_rdy,
                                            input logic dav, input logic more);
        crb_flags_t f;
        f.valid   = valid;
        f.cmd_rdy = cmd_rdy;
        f.dav     = dav;
        f.more    = more;
        return f;
    endfunction

endpackage

// File: rtl/crb_buffer.sv
module crb_buffer
    import crb_pkg::*;
#(
    parameter int BUF_BYTES = 1024,
    parameter int AW        = 10
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [31:0]   hdr_len
);

    logic [7:0] mem [BUF_BYTES];
    logic [7:0] hb  [HDR_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

    // Header bytes, with the byte being written this cycle forwarded
    for (genvar k = 0; k < HDR_BYTES; k++) begin : g_hdr
        localparam logic [AW-1:0] IDX = AW'(HDR_FIRST + k);
        assign hb[k] = (wr_en && wr_addr == IDX) ? wr_data : mem[HDR_FIRST + k];
    end

    assign hdr_len = {hb[0], hb[1], hb[2], hb[3]};

endmodule

// File: rtl/crb_fsm.sv
module crb_fsm
    import crb_pkg::*;
#(
    parameter int BUF_BYTES = 1024,
    parameter int OFFW      = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sts_wr,
    input  logic            fifo_wr,
    input  logic            fifo_rd,
    input  logic [7:0]      wdata,
    input  logic [31:0]     hdr_len,
    input  logic            eng_ack,
    input  logic            eng_selftest,
    output crb_state_e      state,
    output crb_flags_t      flags,
    output logic [OFFW-1:0] offset,
    output logic [OFFW-1:0] rsp_len,
    output logic [OFFW-1:0] cmd_len,
    output logic            stest,
    output logic            host_we,
    output logic            req,
    output logic            cancel,
    output logic            ev_cr,
    output logic            ev_val,
    output logic            ev_dav
);

    localparam logic [OFFW-1:0] BUF_L  = OFFW'(BUF_BYTES);
    localparam logic [OFFW-1:0] HDR_L  = OFFW'(HDR_END - 1);

    crb_state_e      st_q, st_d;
    crb_flags_t      fl_q, fl_d;
    logic [OFFW-1:0] off_q, off_d, len_q, len_d;
    logic            stest_q, stest_d, abort_q, abort_d;
    logic            req_d, cancel_d, ev_cr_d, ev_val_d, ev_dav_d;
    logic            need_ev;
    crb_op_e         op;

    assign op      = decode_op(wdata);
    assign rsp_len = (hdr_len > 32'(BUF_BYTES)) ? BUF_L : hdr_len[OFFW-1:0];

    always_comb begin
        st_d     = st_q;
        fl_d     = fl_q;
        off_d    = off_q;
        len_d    = len_q;
        stest_d  = stest_q;
        abort_d  = abort_q;
        req_d    = 1'b0;
        cancel_d = 1'b0;
        ev_cr_d  = 1'b0;
        ev_val_d = 1'b0;
        ev_dav_d = 1'b0;
        host_we  = 1'b0;
        need_ev  = 1'b0;

        if (eng_ack && st_q == ST_EXEC) begin
            off_d    = '0;
            st_d     = ST_DONE;
            fl_d     = flags_of(1'b1, 1'b0, 1'b1, 1'b0);
            ev_val_d = 1'b1;
            ev_dav_d = 1'b1;
            if (eng_selftest) stest_d = 1'b1;
            if (abort_q) begin
                st_d    = ST_READY;
                fl_d    = flags_of(1'b0, 1'b1, 1'b0, 1'b0);
                ev_cr_d = 1'b1;
                abort_d = 1'b0;
            end
        end else if (sts_wr) begin
            unique case (op)
                OP_READY: begin
                    unique case (st_q)
                        ST_IDLE: begin
                            st_d    = ST_READY;
                            fl_d    = flags_of(1'b0, 1'b1, 1'b0, 1'b0);
                            ev_cr_d = 1'b1;
                        end
                        ST_READY: off_d = '0;
                        ST_RECV: begin
                            off_d   = '0;
                            st_d    = ST_READY;
                            fl_d    = flags_of(1'b0, 1'b1, 1'b0, 1'b0);
                            ev_cr_d = 1'b1;
                        end
                        ST_EXEC: begin
                            cancel_d = 1'b1;
                            abort_d  = 1'b1;
                        end
                        ST_DONE: begin
                            off_d   = '0;
                            st_d    = ST_READY;
                            ev_cr_d = !fl_q.cmd_rdy;
                            fl_d    = flags_of(1'b0, 1'b1, 1'b0, 1'b0);
                        end
                        default: ;
                    endcase
                end
                OP_GO: begin
                    if (st_q == ST_RECV && !fl_q.more) begin
                        st_d  = ST_EXEC;
                        req_d = 1'b1;
                        len_d = off_q;
                    end
                end
                OP_RETRY: begin
                    if (st_q == ST_DONE) begin
                        off_d = '0;
                        fl_d  = flags_of(1'b1, 1'b0, 1'b1, 1'b0);
                    end
                end
                default: ;
            endcase
        end else if (fifo_wr && (st_q == ST_READY || st_q == ST_RECV)) begin
            if (st_q == ST_READY) begin
                st_d = ST_RECV;
                fl_d = flags_of(1'b1, 1'b0, 1'b0, 1'b1);
            end
            if (fl_d.more) begin
                if (off_q < BUF_L) begin
                    host_we = 1'b1;
                    off_d   = off_q + 1'b1;
                    if (off_d > HDR_L) begin
                        need_ev   = !fl_d.valid;
                        fl_d.more = (hdr_len > 32'(off_d));
                        fl_d.valid = 1'b1;
                        ev_val_d  = need_ev;
                    end
                end else begin
                    fl_d = flags_of(1'b1, 1'b0, 1'b0, 1'b0);
                end
            end
        end else if (fifo_rd && st_q == ST_DONE && fl_q.dav) begin
            off_d = off_q + 1'b1;
            if (off_d >= rsp_len) begin
                fl_d.dav   = 1'b0;
                fl_d.valid = 1'b1;
                ev_val_d   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            fl_q     <= '0;
            off_q    <= '0;
            len_q    <= '0;
            stest_q  <= 1'b0;
            abort_q  <= 1'b0;
            req      <= 1'b0;
            cancel   <= 1'b0;
            ev_cr    <= 1'b0;
            ev_val   <= 1'b0;
            ev_dav   <= 1'b0;
        end else begin
            st_q     <= st_d;
            fl_q     <= fl_d;
            off_q    <= off_d;
            len_q    <= len_d;
            stest_q  <= stest_d;
            abort_q  <= abort_d;
            req      <= req_d;
            cancel   <= cancel_d;
            ev_cr    <= ev_cr_d;
            ev_val   <= ev_val_d;
            ev_dav   <= ev_dav_d;
        end
    end

    assign state   = st_q;
    assign flags   = fl_q;
    assign offset  = off_q;
    assign cmd_len = len_q;
    assign stest   = stest_q;

    // R6: a request is only ever seen while executing
    assert_req_in_exec_R6: assert property (@(posedge clk) disable iff (rst)
        req |-> st_q == ST_EXEC);
    // R7: data-available lives only in completion
    assert_dav_in_done_R7: assert property (@(posedge clk) disable iff (rst)
        fl_q.dav |-> st_q == ST_DONE);
    // R5: expect lives only in reception
    assert_more_in_recv_R5: assert property (@(posedge clk) disable iff (rst)
        fl_q.more |-> st_q == ST_RECV);
    // R3: command-ready flag implies the ready state
    assert_cmdrdy_in_ready_R3: assert property (@(posedge clk) disable iff (rst)
        fl_q.cmd_rdy |-> st_q == ST_READY);
    // R13: self-test done never drops outside reset
    assert_stest_sticky_R13: assert property (@(posedge clk) disable iff (rst)
        $past(stest_q) |-> stest_q);
    // R14: offset bounded by buffer size
    assert_off_bound_R14: assert property (@(posedge clk) disable iff (rst)
        off_q <= BUF_L);
    // R6: the engine sees a request exactly once per go, then stays quiet
    assert_req_single_R6: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

endmodule

// File: rtl/crb_status.sv
module crb_status
    import crb_pkg::*;
#(
    parameter int         BUF_BYTES = 1024,
    parameter int         OFFW      = 11,
    parameter logic [1:0] FAMILY    = 2'b10
) (
    input  crb_flags_t      flags,
    input  logic            stest,
    input  logic [OFFW-1:0] offset,
    input  logic [OFFW-1:0] rsp_len,
    input  logic            narrow,
    output logic [31:0]     sts_word
);

    localparam logic [OFFW-1:0] BUF_L = OFFW'(BUF_BYTES);

    logic [OFFW-1:0] avail;
    logic [15:0]     burst;
    logic [7:0]      fbyte;

    assign avail = flags.dav ? (rsp_len - offset) : (BUF_L - offset);

    always_comb begin
        burst = 16'(avail);
        if (narrow && burst > 16'd255) burst = 16'd255;
    end

    always_comb begin
        fbyte             = '0;
        fbyte[BIT_VALID]  = flags.valid;
        fbyte[BIT_CMDRDY] = flags.cmd_rdy;
        fbyte[BIT_DAV]    = flags.dav;
        fbyte[BIT_MORE]   = flags.more;
        fbyte[BIT_STEST]  = stest;
    end

    assign sts_word = {2'b00, FAMILY, 4'b0000, burst, fbyte};

endmodule

// File: rtl/crb_ctrl.sv
module crb_ctrl
    import crb_pkg::*;
#(
    parameter int         BUF_BYTES = 1024,
    parameter logic [1:0] FAMILY    = 2'b10,
    localparam int        OFFW      = $clog2(BUF_BYTES + 1),
    localparam int        AW        = $clog2(BUF_BYTES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic            bus_fifo,
    input  logic            bus_narrow,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    output logic [31:0]     sts_rdata,
    output logic            eng_req,
    output logic [OFFW-1:0] eng_len,
    output logic            eng_cancel,
    input  logic            eng_wr,
    input  logic [AW-1:0]   eng_waddr,
    input  logic [7:0]      eng_wdata,
    input  logic            eng_ack,
    input  logic            eng_selftest,
    output logic            ev_cmd_ready,
    output logic            ev_valid,
    output logic            ev_data_avail
);

    crb_state_e      state;
    crb_flags_t      flags;
    logic [OFFW-1:0] offset, rsp_len;
    logic            stest, host_we;
    logic            buf_we;
    logic [AW-1:0]   buf_waddr;
    logic [7:0]      buf_wdata, buf_rdata;
    logic [31:0]     hdr_len;

    assign buf_we    = host_we || (eng_wr && state == ST_EXEC);
    assign buf_waddr = host_we ? offset[AW-1:0] : eng_waddr;
    assign buf_wdata = host_we ? bus_wdata : eng_wdata;

    crb_buffer #(.BUF_BYTES(BUF_BYTES), .AW(AW)) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_addr (buf_waddr),
        .wr_data (buf_wdata),
        .rd_addr (offset[AW-1:0]),
        .rd_data (buf_rdata),
        .hdr_len (hdr_len)
    );

    crb_fsm #(.BUF_BYTES(BUF_BYTES), .OFFW(OFFW)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sts_wr       (bus_wr && !bus_fifo),
        .fifo_wr      (bus_wr && bus_fifo),
        .fifo_rd      (bus_rd && bus_fifo),
        .wdata        (bus_wdata),
        .hdr_len      (hdr_len),
        .eng_ack      (eng_ack),
        .eng_selftest (eng_selftest),
        .state        (state),
        .flags        (flags),
        .offset       (offset),
        .rsp_len      (rsp_len),
        .cmd_len      (eng_len),
        .stest        (stest),
        .host_we      (host_we),
        .req          (eng_req),
        .cancel       (eng_cancel),
        .ev_cr        (ev_cmd_ready),
        .ev_val       (ev_valid),
        .ev_dav       (ev_data_avail)
    );

    crb_status #(.BUF_BYTES(BUF_BYTES), .OFFW(OFFW), .FAMILY(FAMILY)) u_sts (
        .flags    (flags),
        .stest    (stest),
        .offset   (offset),
        .rsp_len  (rsp_len),
        .narrow   (bus_narrow),
        .sts_word (sts_rdata)
    );

    assign bus_rdata = (state == ST_DONE && flags.dav) ? buf_rdata : FILL_BYTE;

    // R10: narrow accesses never see a burst count above one byte
    assert_burst_cap_R10: assert property (@(posedge clk) disable iff (rst)
        bus_narrow |-> sts_rdata[23:8] <= 16'd255);
    // R8: filler byte whenever no response data is pending
    assert_filler_R8: assert property (@(posedge clk) disable iff (rst)
        !sts_rdata[BIT_DAV] |-> bus_rdata == FILL_BYTE);
    // R1: family bits are constant
    assert_family_R1: assert property (@(posedge clk) disable iff (rst)
        sts_rdata[29:28] == FAMILY);

endmodule

// File: tb/tb_crb_ctrl.sv
module tb_crb_ctrl;

    localparam int         BUF   = 320;
    localparam logic [1:0] FAM   = 2'b10;
    localparam int         OFFW  = $clog2(BUF + 1);
    localparam int         AW    = $clog2(BUF);
    localparam logic [7:0] CR    = 8'h40;
    localparam logic [7:0] GO    = 8'h20;
    localparam logic [7:0] RETRY = 8'h02;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 0, bus_rd = 0, bus_fifo = 0, bus_narrow = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic [31:0] sts_rdata;
    logic eng_req, eng_cancel;
    logic [OFFW-1:0] eng_len;
    logic eng_wr = 0, eng_ack = 0, eng_selftest = 0;
    logic [AW-1:0] eng_waddr = 0;
    logic [7:0] eng_wdata = 0;
    logic ev_cmd_ready, ev_valid, ev_data_avail;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk; // 50 MHz

    crb_ctrl #(.BUF_BYTES(BUF), .FAMILY(FAM)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_fifo(bus_fifo),
        .bus_narrow(bus_narrow), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sts_rdata(sts_rdata), .eng_req(eng_req), .eng_len(eng_len),
        .eng_cancel(eng_cancel), .eng_wr(eng_wr), .eng_waddr(eng_waddr),
        .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_selftest(eng_selftest),
        .ev_cmd_ready(ev_cmd_ready), .ev_valid(ev_valid), .ev_data_avail(ev_data_avail)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_sts(input logic [7:0] b);
        @(negedge clk);
        bus_wr = 1; bus_fifo = 0; bus_wdata = b;
        tick();
        bus_wr = 0;
    endtask

    task automatic wr_fifo(input logic [7:0] b);
        @(negedge clk);
        bus_wr = 1; bus_fifo = 1; bus_wdata = b;
        tick();
        bus_wr = 0;
    endtask

    task automatic rd_fifo(output logic [7:0] b);
        @(negedge clk);
        bus_rd = 1; bus_fifo = 1;
        #1 b = bus_rdata;
        tick();
        bus_rd = 0;
    endtask

    function automatic logic [7:0] cmd_byte(input int k, input int len);
        if (k == 0) return 8'h80;
        if (k == 1) return 8'h01;
        if (k <= 5) return 8'((len >> (8 * (5 - k))) & 32'hFF);
        return 8'((k * 3 + 1) & 255);
    endfunction

    function automatic logic [7:0] rsp_byte(input int k, input int len);
        if (k == 0) return 8'hA5;
        if (k == 1) return 8'h5A;
        if (k <= 5) return 8'((len >> (8 * (5 - k))) & 32'hFF);
        return 8'((k * 13 + len) & 255);
    endfunction

    task automatic run_engine(input int m, input logic st);
        for (int i = 0; i < m; i++) begin
            @(negedge clk);
            eng_wr = 1; eng_waddr = AW'(i); eng_wdata = rsp_byte(i, m);
            tick();
        end
        eng_wr = 0;
        @(negedge clk);
        eng_ack = 1; eng_selftest = st;
        tick();
        eng_ack = 0; eng_selftest = 0;
    endtask

    function automatic logic [31:0] burst();
        return 32'(sts_rdata[23:8]);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        int m;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 flags", 32'(sts_rdata[7:0]), 32'h0);
        chk("R1 burst", burst(), BUF);
        chk("R1 family", 32'(sts_rdata[29:28]), 32'(FAM));
        rd_fifo(b);
        chk("R8 idle read filler", 32'(b), 32'hFF);
        // R10 narrow cap
        bus_narrow = 1; #1;
        chk("R10 narrow cap", burst(), 255);
        bus_narrow = 0; #1;
        chk("R10 wide count", burst(), BUF);
        // R4 idle write dropped
        wr_fifo(8'h11);
        chk("R4 idle write flags", 32'(sts_rdata[7:0]), 32'h0);
        chk("R4 idle write burst", burst(), BUF);
        // R2 combinations ignored
        wr_sts(CR | GO);
        chk("R2 cr+go", 32'(sts_rdata[7:0]), 32'h0);
        wr_sts(CR | RETRY);
        chk("R2 cr+retry", 32'(sts_rdata[7:0]), 32'h0);
        wr_sts(GO | RETRY);
        chk("R2 go+retry", 32'(sts_rdata[7:0]), 32'h0);
        wr_sts(CR | GO | RETRY);
        chk("R2 all three", 32'(sts_rdata[7:0]), 32'h0);
        // R3 idle -> ready
        wr_sts(CR);
        chk("R3 cmd ready flag", 32'(sts_rdata[6]), 1);
        chk("R3 event", 32'(ev_cmd_ready), 1);
        wr_sts(CR);
        chk("R3 ready rewind flag", 32'(sts_rdata[7:0]), 32'h40);
        chk("R3 ready rewind burst", burst(), BUF);
        chk("R3 no second event", 32'(ev_cmd_ready), 0);

        for (int len = 6; len <= 20; len++) begin
            for (int k = 0; k < len; k++) begin
                wr_fifo(cmd_byte(k, len));
                if (k == 0) begin
                    chk("R4 first byte flags", 32'(sts_rdata[7:0] & 8'hC8), 32'h88);
                end
                chk("R5 expect", 32'(sts_rdata[3]), 32'((k + 1 <= 5) || (len > k + 1)));
                chk("R10 free space", burst(), BUF - (k + 1));
                if (k == 2) begin
                    wr_sts(GO);
                    chk("R6 early go ignored", 32'(eng_req), 0);
                    chk("R6 early go keeps expect", 32'(sts_rdata[3]), 1);
                end
            end
            wr_sts(GO);
            chk("R6 request", 32'(eng_req), 1);
            chk("R6 length", 32'(eng_len), len);
            wr_fifo(8'h77);
            chk("R4 exec write dropped", burst(), BUF - len);
            m = len + 3;
            run_engine(m, len == 10);
            chk("R7 flags", 32'(sts_rdata[7:0] & 8'hD8), 32'h90);
            chk("R7 events", {30'b0, ev_data_avail, ev_valid}, 3);
            chk("R10 remaining", burst(), m);
            chk("R13 selftest", 32'(sts_rdata[2]), 32'(len >= 10));
            for (int k = 0; k < m; k++) begin
                rd_fifo(b);
                chk("R8 response byte", 32'(b), 32'(rsp_byte(k, m)));
            end
            chk("R8 last read flags", 32'(sts_rdata[7:0] & 8'hD8), 32'h80);
            chk("R8 last read event", 32'(ev_valid), 1);
            chk("R10 after drain", burst(), BUF - m);
            rd_fifo(b);
            chk("R8 drained filler", 32'(b), 32'hFF);
            wr_fifo(8'h55);
            chk("R4 done write dropped", burst(), BUF - m);
            wr_sts(RETRY);
            chk("R9 flags", 32'(sts_rdata[7:0] & 8'hD8), 32'h90);
            chk("R9 burst", burst(), m);
            rd_fifo(b);
            chk("R9 first byte again", 32'(b), 32'hA5);
            wr_sts(CR);
            chk("R12 flags", 32'(sts_rdata[7:0] & 8'hD8), 32'h40);
            chk("R12 event", 32'(ev_cmd_ready), 1);
            chk("R12 burst", burst(), BUF);
        end

        // R11 abort in reception
        wr_fifo(8'h80); wr_fifo(8'h01); wr_fifo(8'h00);
        wr_sts(CR);
        chk("R11 recv abort flags", 32'(sts_rdata[7:0] & 8'hD8), 32'h40);
        chk("R11 recv abort event", 32'(ev_cmd_ready), 1);
        chk("R11 recv abort burst", burst(), BUF);
        // R11 abort in execution
        for (int k = 0; k < 6; k++) wr_fifo(cmd_byte(k, 6));
        wr_sts(GO);
        chk("R6 request abort case", 32'(eng_req), 1);
        wr_sts(CR);
        chk("R11 cancel pulse", 32'(eng_cancel), 1);
        chk("R11 still executing", 32'(sts_rdata[7:0] & 8'hD8), 32'h80);
        run_engine(8, 1'b0);
        chk("R11 exec abort flags", 32'(sts_rdata[7:0] & 8'hD8), 32'h40);
        chk("R11 exec abort event", 32'(ev_cmd_ready), 1);
        chk("R11 exec abort burst", burst(), BUF);
        rd_fifo(b);
        chk("R11 no response data", 32'(b), 32'hFF);
        chk("R13 selftest kept", 32'(sts_rdata[2]), 1);

        // R14 full buffer
        for (int k = 0; k < BUF; k++) wr_fifo(cmd_byte(k, 1000));
        chk("R14 full still expects", 32'(sts_rdata[3]), 1);
        chk("R14 full burst", burst(), 0);
        wr_fifo(8'hEE);
        chk("R14 overflow flags", 32'(sts_rdata[7:0] & 8'hD8), 32'h80);
        chk("R14 offset held", burst(), 0);
        wr_sts(GO);
        chk("R14 go length", 32'(eng_len), BUF);
        run_engine(6, 1'b0);
        chk("R10 six byte response", burst(), 6);

        // R13 reset clears self-test
        @(negedge clk); rst = 1;
        tick(); tick();
        @(negedge clk); rst = 0;
        #1;
        chk("R13 reset clears selftest", 32'(sts_rdata[2]), 0);
        chk("R1 flags after reset", 32'(sts_rdata[7:0]), 32'h0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule